// File: doc/BRIEF.md
# Debug Memory-Transfer Instruction Sequencer

This block drives bulk data moves between a debug data register and the register file, data SRAM or program flash of a small processor core. A debug host loads a mode code, a start value and a stop value. It then fires either a run strobe or a single-step strobe. The sequencer walks an internal step counter from the start value up to, but not including, the stop value. On each step it emits one 16-bit instruction word for the core to execute.

Some steps move a byte through the debug data register. On those steps the block raises a byte request and holds the word until the host acknowledges. The request carries a direction: whether the host must supply the byte or will receive it. When the last step completes, the block pulses done and returns to idle. Instruction decode and the memories themselves lie outside the block.

Top module: `mem_xfer_seq`

## Requirements
- R1: Only bits 2:0 of the mode byte are decoded. Code 0 is SRAM read, 1 is register read, 2 is flash read, 4 is SRAM write and 5 is register write. Codes 3, 6 and 7 emit no word and pulse done one cycle after the strobe.
- R2: Register modes emit the word {1011, X, 11, pc[4:0], 0001} on every step, with X=1 for read and X=0 for write (read base 0xBE01, write base 0xB601). Every step needs a byte handshake.
- R3: SRAM modes emit a memory op on even steps with no handshake: 0x9101 for read, 0x9301 for write. They emit a data-register op on odd steps with a handshake: 0xBF01 for read, 0xB701 for write.
- R4: Flash read emits 0x9105 on even steps with no handshake, and 0xBF01 on odd steps with a handshake.
- R5: A run strobe (go_i) steps pc_o from the start value while it is below the stop value, with one word per step. Start 0 and stop 0x20 in register mode gives 32 words. Start 0 and stop 0x100 in flash mode gives 128 byte handshakes.
- R6: A single-step strobe (step_i, with go_i low) emits exactly one word, at the start value, and then finishes. If both strobes are high, go_i wins.
- R7: While byte_req_o is high and byte_ack_i is low, the word and pc_o hold. byte_in_o is 1 when the host supplies the byte (write modes) and 0 when it receives it.
- R8: done_o is high for exactly one cycle, in the cycle after the last step is accepted, and the block is then idle. If the start value is not below the stop value, no word is emitted and done_o pulses one cycle after the strobe.
- R9: After reset, and whenever idle, instr_valid_o, byte_req_o, byte_in_o and done_o are 0, and instr_o is 0.
- R10: Mode, start and stop are captured at the strobe. Strobes and input changes during a transfer have no effect on it.
- R11: A step without a byte handshake lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 8 | Transfer mode byte |
| start_pc_i | input | PC_W | First step value |
| stop_pc_i | input | PC_W | Exclusive end step value |
| go_i | input | 1 | Run the whole range |
| step_i | input | 1 | Run a single step |
| byte_ack_i | input | 1 | Host completes the pending byte |
| instr_o | output | 16 | Instruction word for the core |
| instr_valid_o | output | 1 | instr_o is valid (transfer active) |
| byte_req_o | output | 1 | Current step moves a data byte |
| byte_in_o | output | 1 | 1: host supplies the byte, 0: host receives it |
| pc_o | output | PC_W | Current step value |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions check on every cycle that a pending byte freezes the word and the step value, and that a step without a handshake advances the step value by one. They also check that a handshake is requested exactly when the word is a data-register access, and that the direction agrees with that word's in/out bit. Finally they check that done is a lone pulse and that the block is quiet when idle.

Only the bench scenarios can show the exact word values per mode and step parity, and the word and byte counts for a given range. The same holds for the single-step and empty-range endings, the rejection of undefined mode codes, and the capture of inputs at the strobe.

// File: rtl/mem_xfer_pkg.sv
package mem_xfer_pkg;
  typedef enum logic [1:0] {
    KIND_SRAM  = 2'd0,
    KIND_REG   = 2'd1,
    KIND_FLASH = 2'd2,
    KIND_NONE  = 2'd3
  } xfer_kind_e;

  localparam int unsigned WORD_W = 16;
  localparam int unsigned RSEL_W = 5;

  function automatic xfer_kind_e decode_kind(input logic [2:0] code);
    case (code)
      3'd0, 3'd4: decode_kind = KIND_SRAM;
      3'd1, 3'd5: decode_kind = KIND_REG;
      3'd2:       decode_kind = KIND_FLASH;
      default:    decode_kind = KIND_NONE;
    endcase
  endfunction

  // data-register access: out (x=1) or in (x=0)
  function automatic logic [WORD_W-1:0] io_word(input logic x, input logic [RSEL_W-1:0] r);
    io_word = {4'b1011, x, 2'b11, r, 4'b0001};
  endfunction

  // post-increment Z load/store
  function automatic logic [WORD_W-1:0] ldst_word(input logic st, input logic [RSEL_W-1:0] r);
    ldst_word = {6'b100100, st, r, 4'b0001};
  endfunction

  // post-increment Z program-memory load
  function automatic logic [WORD_W-1:0] lpm_word(input logic [RSEL_W-1:0] r);
    lpm_word = {7'b1001000, r, 4'b0101};
  endfunction
endpackage

// File: rtl/xfer_word_gen.sv
module xfer_word_gen
  import mem_xfer_pkg::*;
#(
  parameter int unsigned PC_W     = 16,
  parameter logic [4:0]  SCRATCH_R = 5'd16
) (
  input  xfer_kind_e        kind_i,
  input  logic              wr_i,
  input  logic [PC_W-1:0]   pc_i,
  output logic [WORD_W-1:0] word_o,
  output logic              needs_byte_o,
  output logic              byte_in_o
);
  logic odd_step;
  assign odd_step = pc_i[0];

  always_comb begin
    word_o       = '0;
    needs_byte_o = 1'b0;
    byte_in_o    = 1'b0;
    unique case (kind_i)
      KIND_REG: begin
        word_o       = io_word(~wr_i, pc_i[RSEL_W-1:0]);
        needs_byte_o = 1'b1;
        byte_in_o    = wr_i;
      end
      KIND_SRAM: begin
        if (odd_step) begin
          word_o       = io_word(~wr_i, SCRATCH_R);
          needs_byte_o = 1'b1;
          byte_in_o    = wr_i;
        end else begin
          word_o = ldst_word(wr_i, SCRATCH_R);
        end
      end
      KIND_FLASH: begin
        if (odd_step) begin
          word_o       = io_word(1'b1, SCRATCH_R);
          needs_byte_o = 1'b1;
        end else begin
          word_o = lpm_word(SCRATCH_R);
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/xfer_step_ctrl.sv
module xfer_step_ctrl
  import mem_xfer_pkg::*;
#(
  parameter int unsigned PC_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [2:0]      code_i,
  input  logic [PC_W-1:0] start_i,
  input  logic [PC_W-1:0] stop_i,
  input  logic            go_i,
  input  logic            step_i,
  input  logic            needs_byte_i,
  input  logic            byte_ack_i,
  output logic            busy_o,
  output logic [PC_W-1:0] pc_o,
  output xfer_kind_e      kind_o,
  output logic            wr_o,
  output logic            done_o
);
  logic            busy_q, single_q, wr_q, done_q;
  logic [PC_W-1:0] pc_q, stop_q;
  xfer_kind_e      kind_q;

  xfer_kind_e      new_kind;
  logic            launch, empty_range, advance, last_step;
  logic [PC_W-1:0] pc_inc;

  assign new_kind    = decode_kind(code_i);
  assign launch      = ~busy_q & (go_i | step_i);
  assign empty_range = (new_kind == KIND_NONE) | (start_i >= stop_i);
  assign advance     = busy_q & (~needs_byte_i | byte_ack_i);
  assign pc_inc      = pc_q + 1'b1;
  assign last_step   = single_q | (pc_inc == stop_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      single_q <= 1'b0;
      wr_q     <= 1'b0;
      done_q   <= 1'b0;
      pc_q     <= '0;
      stop_q   <= '0;
      kind_q   <= KIND_NONE;
    end else begin
      done_q <= 1'b0;
      if (launch) begin
        pc_q     <= start_i;
        stop_q   <= stop_i;
        kind_q   <= new_kind;
        wr_q     <= code_i[2];
        single_q <= ~go_i;
        if (empty_range) done_q <= 1'b1;
        else             busy_q <= 1'b1;
      end else if (advance) begin
        pc_q <= pc_inc;
        if (last_step) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign pc_o   = pc_q;
  assign kind_o = busy_q ? kind_q : KIND_NONE;
  assign wr_o   = wr_q;
  assign done_o = done_q;
endmodule

// File: rtl/mem_xfer_seq.sv
module mem_xfer_seq
  import mem_xfer_pkg::*;
#(
  parameter int unsigned PC_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        mode_i,
  input  logic [PC_W-1:0]   start_pc_i,
  input  logic [PC_W-1:0]   stop_pc_i,
  input  logic              go_i,
  input  logic              step_i,
  input  logic              byte_ack_i,
  output logic [WORD_W-1:0] instr_o,
  output logic              instr_valid_o,
  output logic              byte_req_o,
  output logic              byte_in_o,
  output logic [PC_W-1:0]   pc_o,
  output logic              done_o
);
  logic            busy, wr, needs_byte, dir_in;
  logic [PC_W-1:0] pc;
  xfer_kind_e      kind;
  logic [WORD_W-1:0] word;
  logic            unused_mode_hi;

  assign unused_mode_hi = ^mode_i[7:3];

  xfer_step_ctrl #(.PC_W(PC_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .code_i       (mode_i[2:0]),
    .start_i      (start_pc_i),
    .stop_i       (stop_pc_i),
    .go_i         (go_i),
    .step_i       (step_i),
    .needs_byte_i (needs_byte),
    .byte_ack_i   (byte_ack_i),
    .busy_o       (busy),
    .pc_o         (pc),
    .kind_o       (kind),
    .wr_o         (wr),
    .done_o       (done_o)
  );

  xfer_word_gen #(.PC_W(PC_W)) u_gen (
    .kind_i       (kind),
    .wr_i         (wr),
    .pc_i         (pc),
    .word_o       (word),
    .needs_byte_o (needs_byte),
    .byte_in_o    (dir_in)
  );

  assign instr_valid_o = busy;
  assign instr_o       = busy ? word : '0;
  assign byte_req_o    = busy & needs_byte;
  assign byte_in_o     = busy & needs_byte & dir_in;
  assign pc_o          = pc;
endmodule

// File: rtl/mem_xfer_seq_chk.sv
module mem_xfer_seq_chk #(
  parameter int unsigned PC_W = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            byte_ack_i,
  input logic [15:0]     instr_o,
  input logic            instr_valid_o,
  input logic            byte_req_o,
  input logic            byte_in_o,
  input logic [PC_W-1:0] pc_o,
  input logic            done_o
);
  p_hold_while_waiting_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_o && byte_req_o && !byte_ack_i |=>
      instr_valid_o && $stable(instr_o) && $stable(pc_o));

  p_one_cycle_step_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_o && !byte_req_o |=> pc_o == $past(pc_o) + 1'b1);

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !instr_valid_o);

  p_req_matches_io_word_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_o |-> byte_req_o == (instr_o[15:12] == 4'b1011));

  p_dir_matches_word_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_req_o |-> byte_in_o == !instr_o[11]);

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_valid_o |-> instr_o == 16'h0 && !byte_req_o && !byte_in_o);
endmodule

bind mem_xfer_seq mem_xfer_seq_chk #(.PC_W(PC_W)) u_chk (.*);

// File: tb/mem_xfer_seq_tb_top.sv
module mem_xfer_seq_tb_top;
  localparam int PC_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] mode = 8'h0;
  logic [PC_W-1:0] start_pc = '0, stop_pc = '0;
  logic go = 1'b0, step = 1'b0, ack = 1'b0;
  logic [15:0] instr;
  logic valid, req, byte_in, done;
  logic [PC_W-1:0] pc;

  always #10 clk = ~clk;

  mem_xfer_seq #(.PC_W(PC_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .start_pc_i(start_pc),
    .stop_pc_i(stop_pc), .go_i(go), .step_i(step), .byte_ack_i(ack),
    .instr_o(instr), .instr_valid_o(valid), .byte_req_o(req),
    .byte_in_o(byte_in), .pc_o(pc), .done_o(done));

  int n_chk = 0, n_err = 0, cyc = 0;
  int lat = 0, wcnt = 0;
  int words = 0, bytes = 0;
  bit saw_done = 0;

  // ---------- reference model ----------
  bit m_busy, m_single, m_done;
  int m_pc, m_stop, m_code;

  function automatic bit code_ok(int c);
    return c == 0 || c == 1 || c == 2 || c == 4 || c == 5;
  endfunction
  function automatic bit needs(int c, int p);
    if (c == 1 || c == 5) return 1;
    return p % 2 == 1;
  endfunction
  function automatic logic [15:0] exp_word(int c, int p);
    case (c)
      1: return 16'hBE01 | 16'((p % 32) << 4);
      5: return 16'hB601 | 16'((p % 32) << 4);
      0: return (p % 2 == 1) ? 16'hBF01 : 16'h9101;
      4: return (p % 2 == 1) ? 16'hB701 : 16'h9301;
      2: return (p % 2 == 1) ? 16'hBF01 : 16'h9105;
      default: return 16'h0;
    endcase
  endfunction
  function automatic string word_tag(int c);
    case (c)
      1, 5: return "R2";
      0, 4: return "R3";
      2: return "R4";
      default: return "R1";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    bit nd;
    if (!rst_n) begin
      m_busy = 0; m_single = 0; m_done = 0; m_pc = 0; m_stop = 0; m_code = 7;
    end else begin
      nd = 0;
      if (!m_busy) begin
        if (go || step) begin
          m_code = int'(mode) % 8; m_pc = int'(start_pc); m_stop = int'(stop_pc);
          m_single = !go;
          if (code_ok(m_code) && m_pc < m_stop) m_busy = 1;
          else nd = 1;
        end
      end else if (!needs(m_code, m_pc) || ack) begin
        m_pc++;
        if (m_single || m_pc >= m_stop) begin m_busy = 0; nd = 1; end
      end
      m_done = nd;
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  // called at a negedge: compare, answer handshake, advance one cycle
  task automatic tick();
    if (rst_n) begin
      chk("R5", "instr_valid", 32'(valid), 32'(m_busy));
      chk("R8", "done", 32'(done), 32'(m_done));
      if (m_busy) begin
        chk(word_tag(m_code), "instr", 32'(instr), 32'(exp_word(m_code, m_pc)));
        chk("R5/R11", "pc", 32'(pc), 32'(m_pc));
        chk("R7", "byte_req", 32'(req), 32'(needs(m_code, m_pc)));
        if (needs(m_code, m_pc)) chk("R7", "byte_in", 32'(byte_in), 32'(m_code >= 4));
      end else begin
        chk("R9", "idle instr", 32'(instr), 32'h0);
        chk("R9", "idle req", 32'(req), 32'h0);
      end
    end
    if (done) saw_done = 1;
    if (req) begin
      if (wcnt >= lat) begin ack = 1; wcnt = 0; end
      else begin ack = 0; wcnt++; end
    end else begin ack = 0; wcnt = 0; end
    if (valid && (!req || ack)) words++;
    if (req && ack) bytes++;
    cyc++;
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
      finish_sim();
    end
    @(negedge clk);
  endtask

  task automatic run(string tag, logic [7:0] m, int s, int e, bit single, int l, bit disturb);
    int c, exp_w, exp_b, n;
    c = int'(m) % 8;
    lat = l; words = 0; bytes = 0; saw_done = 0;
    exp_w = 0; exp_b = 0;
    if (code_ok(c) && s < e) begin
      n = single ? 1 : e - s;
      for (int p = s; p < s + n; p++) begin
        exp_w++;
        if (needs(c, p)) exp_b++;
      end
    end
    mode = m; start_pc = PC_W'(s); stop_pc = PC_W'(e);
    go = !single; step = single;
    tick();
    go = 0; step = 0;
    for (int i = 0; i < 4000 && !saw_done; i++) begin
      if (disturb && i == 2) begin
        go = 1; mode = 8'h02; start_pc = '0; stop_pc = PC_W'(9);
      end
      if (disturb && i == 3) go = 0;
      tick();
    end
    chk(tag, "done seen", 32'(saw_done), 32'h1);
    chk(tag, "word count", 32'(words), 32'(exp_w));
    chk(tag, "byte count", 32'(bytes), 32'(exp_b));
    tick();
  endtask

  initial begin
    @(negedge clk);
    chk("R9", "reset valid", 32'(valid), 32'h0);
    chk("R9", "reset done", 32'(done), 32'h0);
    chk("R9", "reset instr", 32'(instr), 32'h0);
    chk("R9", "reset req", 32'(req), 32'h0);
    @(negedge clk);
    rst_n = 1;
    tick(); tick();
    run("R2 R5", 8'h01, 0, 32, 0, 0, 0);        // 32 register reads
    run("R2", 8'h05, 0, 32, 0, 1, 0);           // register writes
    run("R6", 8'h05, 3, 4, 1, 2, 0);            // single register write
    run("R6", 8'h01, 5, 20, 1, 0, 0);           // single step in long range
    run("R3 R11", 8'h00, 0, 2, 0, 2, 0);        // one SRAM read
    run("R3", 8'h04, 1, 3, 0, 1, 0);            // one SRAM write
    run("R3", 8'h00, 0, 10, 0, 3, 0);           // several SRAM reads
    run("R4 R5", 8'h02, 0, 256, 0, 1, 0);       // flash page 128 bytes
    run("R1", 8'h03, 0, 8, 0, 0, 0);            // undefined code
    run("R1", 8'h06, 0, 8, 0, 0, 0);
    run("R1", 8'hF9, 2, 6, 0, 0, 0);            // high bits ignored
    run("R8", 8'h01, 7, 7, 0, 0, 0);            // empty range
    run("R8", 8'h00, 9, 4, 1, 0, 0);            // reversed range
    run("R10", 8'h05, 4, 12, 0, 2, 1);          // strobe mid-run
    run("R5", 8'h01, 16'hFFF0, 16'hFFFF, 0, 0, 0); // top of range
    finish_sim();
  end
endmodule